// File: doc/BRIEF.md
# Indirect Register Access Bridge for a Two-Wire Serial Core

This block connects a 64-bit memory-mapped command register to the small byte-wide register bus of a two-wire serial controller core. Software does not address the core's registers directly. It writes one command word with its valid flag set and then polls that flag. The bridge reads the operation code and the 3-bit register sub-index from the word. It runs one access on the core bus and then clears the flag. On a read, it places the fetched byte in the low data field of the same word.

The core side is a single request strobe with a one-hot register select, a write enable and a write byte. The core answers a read one cycle after the strobe. The read/write flag is part of the register selection, so sub-index 3 reaches the clock-control register on a write and the status register on a read. Operation codes other than direct access, and sub-indices that name no register, finish at once and return zero.

Top module: `i2c_reg_bridge`

## Requirements
- R1: After a synchronous active-high reset, the command word reads as all zeros and no core access is driven.
- R2: A host write with bit 63 (valid) set, made while the stored valid bit is 0, is accepted. From the next cycle the whole written word reads back, with bit 63 still set.
- R3: A host write made while the stored valid bit is 1 is ignored, and the word in flight is not changed by it.
- R4: With op (bits 60:57) equal to 6, eop_ia (bits 34:32) selects one core register on the one-hot select bus. The select bits are: 0 slave address, 1 data, 2 control, 3 clock control, 4 status, 5 extended slave address, 6 soft reset. eop_ia 0, 1, 2, 4 and 7 map to bits 0, 1, 2, 5 and 6.
- R5: With eop_ia equal to 3, a write (bit 56 equal to 0) selects clock control (select bit 3) and a read (bit 56 equal to 1) selects status (select bit 4).
- R6: A supported access drives exactly one cycle of core request, in the cycle after acceptance. A write drives the write enable and places data bits 7:0 on the write byte.
- R7: A supported read completes with data bits 31:0 equal to the byte from the core, zero-extended. A supported write completes with the data field unchanged. All other fields keep the values that were written.
- R8: A supported access clears the valid bit exactly 2 cycles after the accepting clock edge.
- R9: An op other than 6, or eop_ia equal to 5 or 6, drives no core request. It clears the valid bit 1 cycle after acceptance and sets data bits 31:0 to zero.
- R10: Once the valid bit has cleared, the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word, with the valid flag and the result |
| core_req | output | 1 | One-cycle access strobe to the core |
| core_sel | output | 7 | One-hot core register select |
| core_we | output | 1 | 1 = write access, 0 = read access |
| core_wdata | output | 8 | Byte written to the selected register |
| core_rdata | input | 8 | Byte returned by the core one cycle after a read strobe |

## Verification
A sequencer stuck in a state, or one that skips a state, shows up at the host port within one or two cycles. The valid flag then clears a cycle early, clears a cycle late, or never clears, and each command's completion delay is measured against 2 or 1. A wrong decode shows on the select bus in the single strobe cycle. It also shows in the returned byte: a clock-control write must not be visible through the status read of the same sub-index. A corrupted hold of the word in flight appears in the readback of the stray fields and the data field once the flag drops.

// File: rtl/i2c_bridge_pkg.sv
package i2c_bridge_pkg;

    localparam int CMD_W     = 64;
    localparam int DATA_W    = 32;
    localparam int REG_W     = 8;
    localparam int NUM_REGS  = 7;
    localparam int EOP_LSB   = 32;
    localparam int EOP_W     = 3;
    localparam int RD_BIT    = 56;
    localparam int OP_LSB    = 57;
    localparam int OP_W      = 4;
    localparam int V_BIT     = 63;

    localparam logic [OP_W-1:0] OP_DIRECT = 4'd6;

    // Positions on the one-hot core select bus
    localparam int SEL_SLAVE     = 0;
    localparam int SEL_DATA      = 1;
    localparam int SEL_CTL       = 2;
    localparam int SEL_CLKCTL    = 3;
    localparam int SEL_STATUS    = 4;
    localparam int SEL_SLAVE_EXT = 5;
    localparam int SEL_RESET     = 6;

    typedef struct packed {
        logic                legal;
        logic                is_rd;
        logic [NUM_REGS-1:0] sel;
        logic [REG_W-1:0]    wdata;
    } access_t;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ISSUE   = 2'd1,
        SEQ_CAPTURE = 2'd2
    } seq_state_e;

    // Sub-index plus direction -> one-hot register; zero when nothing is mapped
    function automatic logic [NUM_REGS-1:0] sel_for(input logic [EOP_W-1:0] idx,
                                                    input logic rd);
        logic [NUM_REGS-1:0] s;
        s = '0;
        case (idx)
            3'd0:    s[SEL_SLAVE]     = 1'b1;
            3'd1:    s[SEL_DATA]      = 1'b1;
            3'd2:    s[SEL_CTL]       = 1'b1;
            3'd3:    s[rd ? SEL_STATUS : SEL_CLKCTL] = 1'b1;
            3'd4:    s[SEL_SLAVE_EXT] = 1'b1;
            3'd7:    s[SEL_RESET]     = 1'b1;
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/i2c_bridge_decode.sv
module i2c_bridge_decode
    import i2c_bridge_pkg::*;
#(
    parameter int P_OP_W  = OP_W,
    parameter int P_EOP_W = EOP_W,
    parameter int P_REG_W = REG_W
) (
    input  logic [P_OP_W-1:0]  op,
    input  logic               rd,
    input  logic [P_EOP_W-1:0] eop,
    input  logic [P_REG_W-1:0] data_lo,
    output access_t            acc
);
    logic [NUM_REGS-1:0] sel_raw;

    always_comb begin
        sel_raw   = sel_for(eop, rd);
        acc.legal = (op == OP_DIRECT) && (|sel_raw);
        acc.is_rd = rd;
        acc.sel   = acc.legal ? sel_raw : '0;
        acc.wdata = data_lo;
    end
endmodule

// File: rtl/i2c_bridge_seq.sv
module i2c_bridge_seq
    import i2c_bridge_pkg::*;
#(
    parameter int P_NUM_REGS = NUM_REGS,
    parameter int P_REG_W    = REG_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  launch,
    input  access_t               acc,
    output logic                  core_req,
    output logic [P_NUM_REGS-1:0] core_sel,
    output logic                  core_we,
    output logic [P_REG_W-1:0]    core_wdata,
    output logic                  done,
    output logic                  load_rd,
    output logic                  load_zero
);
    seq_state_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        core_req  = 1'b0;
        done      = 1'b0;
        load_rd   = 1'b0;
        load_zero = 1'b0;
        case (state_q)
            SEQ_IDLE:    if (launch) state_d = SEQ_ISSUE;
            SEQ_ISSUE: begin
                if (acc.legal) begin
                    core_req = 1'b1;
                    state_d  = SEQ_CAPTURE;
                end else begin
                    done      = 1'b1;
                    load_zero = 1'b1;
                    state_d   = SEQ_IDLE;
                end
            end
            SEQ_CAPTURE: begin
                done    = 1'b1;
                load_rd = acc.is_rd;
                state_d = SEQ_IDLE;
            end
            default:     state_d = SEQ_IDLE;
        endcase
        core_sel   = core_req ? acc.sel : '0;
        core_we    = core_req & ~acc.is_rd;
        core_wdata = core_req ? acc.wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_IDLE;
        else     state_q <= state_d;
    end

    assert_one_sel_R4: assert property (@(posedge clk) disable iff (rst)
        core_req |-> ($countones(core_sel) == 1));
    assert_quiet_sel_R4: assert property (@(posedge clk) disable iff (rst)
        !core_req |-> (core_sel == '0));
    assert_single_req_R6: assert property (@(posedge clk) disable iff (rst)
        core_req |=> !core_req);
endmodule

// File: rtl/i2c_bridge_cmdreg.sv
module i2c_bridge_cmdreg
    import i2c_bridge_pkg::*;
#(
    parameter int P_CMD_W  = CMD_W,
    parameter int P_DATA_W = DATA_W,
    parameter int P_REG_W  = REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               host_we,
    input  logic [P_CMD_W-1:0] host_wdata,
    input  logic               done,
    input  logic               load_rd,
    input  logic               load_zero,
    input  logic [P_REG_W-1:0] rd_byte,
    output logic [P_CMD_W-1:0] word_q,
    output logic               launch
);
    localparam int PAD_W = P_DATA_W - P_REG_W;

    assign launch = host_we && host_wdata[V_BIT] && !word_q[V_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (launch) begin
            word_q <= host_wdata;
        end else if (done) begin
            word_q[V_BIT] <= 1'b0;
            if (load_zero)
                word_q[P_DATA_W-1:0] <= '0;
            else if (load_rd)
                word_q[P_DATA_W-1:0] <= {{PAD_W{1'b0}}, rd_byte};
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        launch |=> (word_q == $past(host_wdata)));
    assert_busy_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (word_q[V_BIT] && !done) |=> $stable(word_q));
endmodule

// File: rtl/i2c_reg_bridge.sv
module i2c_reg_bridge
    import i2c_bridge_pkg::*;
#(
    parameter int P_CMD_W    = CMD_W,
    parameter int P_DATA_W   = DATA_W,
    parameter int P_REG_W    = REG_W,
    parameter int P_NUM_REGS = NUM_REGS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_we,
    input  logic [P_CMD_W-1:0]    host_wdata,
    output logic [P_CMD_W-1:0]    host_rdata,
    output logic                  core_req,
    output logic [P_NUM_REGS-1:0] core_sel,
    output logic                  core_we,
    output logic [P_REG_W-1:0]    core_wdata,
    input  logic [P_REG_W-1:0]    core_rdata
);
    logic [P_CMD_W-1:0] word_q;
    logic    launch, done, load_rd, load_zero;
    access_t acc;

    i2c_bridge_cmdreg #(.P_CMD_W(P_CMD_W), .P_DATA_W(P_DATA_W), .P_REG_W(P_REG_W)) u_cmd (
        .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
        .done(done), .load_rd(load_rd), .load_zero(load_zero),
        .rd_byte(core_rdata), .word_q(word_q), .launch(launch)
    );

    i2c_bridge_decode #(.P_OP_W(OP_W), .P_EOP_W(EOP_W), .P_REG_W(P_REG_W)) u_dec (
        .op(word_q[OP_LSB +: OP_W]), .rd(word_q[RD_BIT]),
        .eop(word_q[EOP_LSB +: EOP_W]), .data_lo(word_q[P_REG_W-1:0]), .acc(acc)
    );

    i2c_bridge_seq #(.P_NUM_REGS(P_NUM_REGS), .P_REG_W(P_REG_W)) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .acc(acc),
        .core_req(core_req), .core_sel(core_sel), .core_we(core_we),
        .core_wdata(core_wdata), .done(done), .load_rd(load_rd), .load_zero(load_zero)
    );

    assign host_rdata = word_q;

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        core_req |=> (host_rdata[V_BIT] ##1 !host_rdata[V_BIT]));
    assert_idle_bus_R9: assert property (@(posedge clk) disable iff (rst)
        !host_rdata[V_BIT] |-> !core_req);
endmodule

// File: tb/sim_i2c_reg_bridge.sv
module sim_i2c_reg_bridge;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        core_req, core_we;
    logic [6:0]  core_sel;
    logic [7:0]  core_wdata;
    logic [7:0]  core_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    i2c_reg_bridge u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .core_req(core_req), .core_sel(core_sel),
        .core_we(core_we), .core_wdata(core_wdata), .core_rdata(core_rdata)
    );

    // Core register model: status (index 4) preset to F8, answers reads a cycle later
    logic [7:0] mem [7];
    int         req_count;
    logic [6:0] last_sel;
    logic       last_we;
    logic [7:0] last_wd;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 7; k++) mem[k] <= (k == 4) ? 8'hF8 : 8'h00;
            core_rdata <= '0;
            req_count  <= 0;
            last_sel   <= '0;
            last_we    <= 1'b0;
            last_wd    <= '0;
        end else if (core_req) begin
            req_count <= req_count + 1;
            last_sel  <= core_sel;
            last_we   <= core_we;
            last_wd   <= core_wdata;
            for (int k = 0; k < 7; k++) begin
                if (core_sel[k]) begin
                    if (core_we) mem[k] <= core_wdata;
                    else         core_rdata <= mem[k];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [3:0] op, input logic rd, input logic [2:0] eop,
                                       input logic [31:0] data, input logic [9:0] addr);
        logic [63:0] w;
        w = '0;
        w[63]    = 1'b1;
        w[60:57] = op;
        w[56]    = rd;
        w[49:40] = addr;
        w[39:35] = 5'h0A;
        w[34:32] = eop;
        w[31:0]  = data;
        return w;
    endfunction

    // Drive one command, return cycles from accepting edge until valid clears
    task automatic run_cmd(input logic [63:0] cmd, output int lat);
        @(negedge clk);
        host_we = 1'b1;
        host_wdata = cmd;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        lat = 0;
        while (host_rdata[63] && lat < 10) begin
            @(negedge clk);
            lat++;
        end
    endtask

    typedef struct packed {
        logic [3:0]  op;
        logic        rd;
        logic [2:0]  eop;
        logic [31:0] data;
        logic [6:0]  sel;
        logic [1:0]  lat;
        logic [31:0] res;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{4'd6, 1'b0, 3'd0, 32'h0000_0077, 7'h01, 2'd2, 32'h0000_0077},
        '{4'd6, 1'b1, 3'd0, 32'h0000_0000, 7'h01, 2'd2, 32'h0000_0077},
        '{4'd6, 1'b0, 3'd1, 32'h0000_00A5, 7'h02, 2'd2, 32'h0000_00A5},
        '{4'd6, 1'b1, 3'd1, 32'hFFFF_FFFF, 7'h02, 2'd2, 32'h0000_00A5},
        '{4'd6, 1'b0, 3'd2, 32'hCAFE_0044, 7'h04, 2'd2, 32'hCAFE_0044},
        '{4'd6, 1'b1, 3'd2, 32'h0000_0000, 7'h04, 2'd2, 32'h0000_0044},
        '{4'd6, 1'b0, 3'd3, 32'h0000_002D, 7'h08, 2'd2, 32'h0000_002D},
        '{4'd6, 1'b1, 3'd3, 32'h0000_0000, 7'h10, 2'd2, 32'h0000_00F8},
        '{4'd6, 1'b0, 3'd4, 32'h0000_003C, 7'h20, 2'd2, 32'h0000_003C},
        '{4'd6, 1'b1, 3'd4, 32'h0000_0000, 7'h20, 2'd2, 32'h0000_003C},
        '{4'd6, 1'b0, 3'd7, 32'h0000_0001, 7'h40, 2'd2, 32'h0000_0001},
        '{4'd1, 1'b1, 3'd1, 32'h1234_5678, 7'h00, 2'd1, 32'h0000_0000},
        '{4'd6, 1'b1, 3'd5, 32'h1234_5678, 7'h00, 2'd1, 32'h0000_0000},
        '{4'd6, 1'b0, 3'd6, 32'h0000_0099, 7'h00, 2'd1, 32'h0000_0000},
        '{4'd15, 1'b0, 3'd2, 32'h0000_0011, 7'h00, 2'd1, 32'h0000_0000}
    };

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        int lat;
        int rc0;
        logic [63:0] cmd, exp_w, other;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(host_rdata == 64'd0, "R1 word after reset", host_rdata, 64'd0);
        chk(core_req == 1'b0, "R1 no core access after reset", {63'd0, core_req}, 64'd0);

        // Table walk: R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            cmd = mk(VEC[i].op, VEC[i].rd, VEC[i].eop, VEC[i].data, 10'(i * 37));
            exp_w = cmd;
            exp_w[63] = 1'b0;
            exp_w[31:0] = VEC[i].res;
            rc0 = req_count;
            run_cmd(cmd, lat);
            chk(lat == int'(VEC[i].lat), $sformatf("R8/R9 latency vec %0d", i),
                64'(lat), 64'(VEC[i].lat));
            chk(host_rdata == exp_w, $sformatf("R7/R9/R10 result word vec %0d", i),
                host_rdata, exp_w);
            if (VEC[i].sel != 7'd0) begin
                chk(req_count == rc0 + 1, $sformatf("R6 one request vec %0d", i),
                    64'(req_count - rc0), 64'd1);
                chk(last_sel == VEC[i].sel, $sformatf("R4/R5 select vec %0d", i),
                    64'(last_sel), 64'(VEC[i].sel));
                chk(last_we == !VEC[i].rd, $sformatf("R6 direction vec %0d", i),
                    64'(last_we), 64'(!VEC[i].rd));
                if (!VEC[i].rd)
                    chk(last_wd == VEC[i].data[7:0], $sformatf("R6 write byte vec %0d", i),
                        64'(last_wd), 64'(VEC[i].data[7:0]));
            end else begin
                chk(req_count == rc0, $sformatf("R9 no request vec %0d", i),
                    64'(req_count - rc0), 64'd0);
            end
        end

        // R2 and R3: second write during busy window is dropped
        cmd   = mk(4'd6, 1'b0, 3'd1, 32'h0000_005A, 10'h155);
        other = mk(4'd6, 1'b1, 3'd3, 32'hDEAD_BEEF, 10'h2AA);
        exp_w = cmd;
        exp_w[63] = 1'b0;
        rc0 = req_count;
        @(negedge clk);
        host_we = 1'b1;
        host_wdata = cmd;
        @(posedge clk);
        @(negedge clk);
        chk(host_rdata == cmd, "R2 readback with valid set", host_rdata, cmd);
        host_wdata = other;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0;
        chk(host_rdata == cmd, "R3 word held while busy", host_rdata, cmd);
        repeat (3) @(negedge clk);
        chk(host_rdata == exp_w, "R3 busy write ignored in result", host_rdata, exp_w);
        chk(req_count == rc0 + 1, "R3 only one access made", 64'(req_count - rc0), 64'd1);
        chk(mem[1] == 8'h5A, "R3 data register got first command", 64'(mem[1]), 64'h5A);

        // R10: accepted again right after completion; data reg read back
        run_cmd(mk(4'd6, 1'b1, 3'd1, 32'h0, 10'h0), lat);
        chk(lat == 2 && host_rdata[31:0] == 32'h5A, "R10 next command after busy",
            {32'(lat), host_rdata[31:0]}, {32'd2, 32'h5A});

        report();
    end
endmodule